// File: doc/BRIEF.md
# Two-Bit to Seven-Bit Lane Gearbox

This block sits behind the serial capture of one lane. On its write clock it takes two freshly deserialized bits per cycle and on an unrelated, faster read clock it hands out seven-bit words. In between is a bit-organised FIFO: a 56-bit circular store that the write side fills two bits at a time and the read side drains seven bits at a time. Each side keeps its own pointer. Each pointer reaches the other clock domain as a Gray-coded count through a two-flop synchronizer.

The input clock runs at 3.5 times the word rate. The read clock is faster than the word rate, so on some read cycles fewer than seven bits are waiting. On those cycles the read side holds its pointer and drops its valid strobe. A word-alignment offset of zero to six bits comes from outside the block. After a read reset the read side discards that many leading bits once, so that later words start on the lane's word boundary.

Each side has its own reset. Both sides start with an empty store. A write that finds fewer than two free bits is dropped and sets a sticky overflow flag.

The write side has two states. WS_CLEAN goes to WS_OVERRUN when a write is refused for lack of room. WS_OVERRUN holds until the write reset. The read side has two states. RS_ALIGN waits until at least the offset number of bits is present, skips them, and moves to RS_STREAM. RS_STREAM delivers one word per read cycle whenever seven or more bits are unread.

Top module: `lane_gearbox`

## Requirements
- R1: While both resets are asserted, out_valid and overflow are 0. After reset the store is empty, so no word appears before bits are written.
- R2: Within a write, din[0] is the earlier bit and din[1] the later one. In dout, bit 0 is the earliest bit of the word and bit 6 the latest. Words come out in arrival order with no bit lost or repeated.
- R3: out_valid is 1 for exactly one read cycle per word. It is raised only when at least 7 unread bits are present. With 6 or fewer bits pending, no word is delivered until more arrive.
- R4: Each side crosses its pointer as a Gray code that changes by at most one bit per cycle, including at the lap wrap. Data stays intact over many laps of the 56-bit store.
- R5: After a read reset, align_ofs (0 to 6) leading bits are discarded once. The first word then starts on the following bit, and no further bits are skipped.
- R6: An align_ofs value of 7 is treated as 6.
- R7: overflow rises on the write cycle after a write meets fewer than 2 free bits. It stays 1 until the write reset. Filling the store to exactly 56 bits does not raise it.
- R8: A refused write leaves the store unchanged. Bits written after the reader frees space are delivered directly after the bits that were accepted earlier.
- R9: With continuous input and a read clock faster than the word rate, no write is refused and overflow stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write (bit) clock |
| wrst_n | input | 1 | Active-low asynchronous reset of the write side |
| din_valid | input | 1 | A bit pair is present on din this cycle |
| din | input | IN_W (2) | Bit pair; bit 0 arrived first |
| overflow | output | 1 | Sticky flag in the write domain: a write was refused |
| rclk | input | 1 | Read (word) clock |
| rrst_n | input | 1 | Active-low asynchronous reset of the read side |
| align_ofs | input | 3 | Leading bits to discard after read reset; held stable |
| dout | output | OUT_W (7) | Output word; bit 0 is the earliest bit |
| out_valid | output | 1 | dout holds a new word this read cycle |

## Verification
A reference bit queue in the bench is fed with every accepted pair and compared against each delivered word. It is driven with bursty random bits, with pairs whose two bits differ (a swapped pair order shows as an inverted alternation), and with a counting pattern. The random run spans many laps of the store, so a fault in the wrap of either pointer or in the Gray crossing corrupts or loses words. Offsets 3 and 7 separate a wrong skip count from a missing clamp. A six-bit remainder followed by one more pair locates the exact threshold of the valid strobe. Holding the reader in reset while the writer fills the store checks where the overflow flag rises, and later words then show whether the refused pairs were kept out of the data.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;

    typedef enum logic {WS_CLEAN, WS_OVERRUN} wr_state_e;
    typedef enum logic {RS_ALIGN, RS_STREAM} rd_state_e;

    function automatic int unsigned to_gray(input int unsigned b);
        return b ^ (b >> 1);
    endfunction

    function automatic int unsigned from_gray(input int unsigned g);
        int unsigned b;
        b = g;
        for (int i = 1; i < 32; i++) b = b ^ (g >> i);
        return b;
    endfunction

    // Lower end of a counting range of 'states' values centred in a
    // 2**w code space; its first and last Gray codes differ in one bit.
    function automatic int unsigned gray_base(input int unsigned states, input int unsigned w);
        return ((32'd1 << w) - states) / 2;
    endfunction

endpackage

// File: rtl/gbx_sync.sv
`timescale 1ns/1ps
module gbx_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gbx_wr.sv
`timescale 1ns/1ps
module gbx_wr import gbx_pkg::*; #(
    parameter int unsigned IN_W  = 2,
    parameter int unsigned OUT_W = 7,
    parameter int unsigned DEPTH = 56
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             din_valid,
    input  logic [IN_W-1:0]                  din,
    input  logic [$clog2(2*DEPTH/OUT_W)-1:0] rd_gray,
    input  logic [$clog2(OUT_W):0]           rd_flag,
    output logic [$clog2(2*DEPTH/IN_W)-1:0]  wr_gray,
    output logic [DEPTH-1:0]                 mem,
    output logic                             overflow
);

    localparam int unsigned SLOTS = DEPTH / IN_W;
    localparam int unsigned WST   = 2 * SLOTS;
    localparam int unsigned PW    = $clog2(WST);
    localparam int unsigned WBASE = gray_base(WST, PW);
    localparam int unsigned RST   = 2 * (DEPTH / OUT_W);
    localparam int unsigned RW    = $clog2(RST);
    localparam int unsigned RBASE = gray_base(RST, RW);
    localparam int unsigned OFS_W = $clog2(OUT_W);
    localparam int unsigned SPAN  = 2 * DEPTH;
    localparam int unsigned AW    = $clog2(DEPTH);

    wr_state_e         st_q, st_d;
    logic [PW-1:0]     wcnt_q;
    logic [PW-1:0]     wgray_q;
    logic [DEPTH-1:0]  mem_q;
    logic [RW-1:0]     rg_s;
    logic [OFS_W:0]    rf_s;

    int unsigned wbits, cons, used, slot, nxt;
    logic        room, take;
    logic [AW-1:0] wpos;

    gbx_sync #(.W(RW), .RST_VAL(RW'(to_gray(RBASE)))) u_rg_sync (
        .clk(clk), .rst_n(rst_n), .d(rd_gray), .q(rg_s)
    );

    gbx_sync #(.W(OFS_W + 1), .RST_VAL('0)) u_rf_sync (
        .clk(clk), .rst_n(rst_n), .d(rd_flag), .q(rf_s)
    );

    // Space check against a consumed count that can only lag the reader.
    always_comb begin
        wbits = (32'(wcnt_q) - WBASE) * IN_W;
        cons  = (from_gray(32'(rg_s)) - RBASE) * OUT_W
              + (rf_s[OFS_W] ? 32'(rf_s[OFS_W-1:0]) : 32'd0);
        used  = (wbits >= cons) ? (wbits - cons) : (wbits + SPAN - cons);
        room  = (used + IN_W) <= DEPTH;
        take  = din_valid && room;
        slot  = (32'(wcnt_q) - WBASE) % SLOTS;
        wpos  = AW'(slot * IN_W);
        nxt   = (32'(wcnt_q) == WBASE + WST - 1) ? WBASE : 32'(wcnt_q) + 1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_CLEAN:   if (din_valid && !room) st_d = WS_OVERRUN;
            WS_OVERRUN: st_d = WS_OVERRUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WS_CLEAN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q  <= PW'(WBASE);
            wgray_q <= PW'(to_gray(WBASE));
            mem_q   <= '0;
        end else if (take) begin
            mem_q[wpos +: IN_W] <= din;
            wcnt_q  <= PW'(nxt);
            wgray_q <= PW'(to_gray(nxt));
        end
    end

    assign wr_gray  = wgray_q;
    assign mem      = mem_q;
    assign overflow = (st_q == WS_OVERRUN);

    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1); // R4
    AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(wcnt_q) - WBASE) < WST); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R7
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(din_valid)); // R7

endmodule

// File: rtl/gbx_rd.sv
`timescale 1ns/1ps
module gbx_rd import gbx_pkg::*; #(
    parameter int unsigned IN_W  = 2,
    parameter int unsigned OUT_W = 7,
    parameter int unsigned DEPTH = 56
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(OUT_W)-1:0]         align_ofs,
    input  logic [$clog2(2*DEPTH/IN_W)-1:0]  wr_gray,
    input  logic [DEPTH-1:0]                 mem,
    output logic [$clog2(2*DEPTH/OUT_W)-1:0] rd_gray,
    output logic [$clog2(OUT_W):0]           rd_flag,
    output logic [OUT_W-1:0]                 dout,
    output logic                             out_valid
);

    localparam int unsigned WST   = 2 * (DEPTH / IN_W);
    localparam int unsigned PW    = $clog2(WST);
    localparam int unsigned WBASE = gray_base(WST, PW);
    localparam int unsigned RST   = 2 * (DEPTH / OUT_W);
    localparam int unsigned RW    = $clog2(RST);
    localparam int unsigned RBASE = gray_base(RST, RW);
    localparam int unsigned OFS_W = $clog2(OUT_W);
    localparam int unsigned SPAN  = 2 * DEPTH;
    localparam int unsigned BW    = $clog2(SPAN);
    localparam int unsigned AW    = $clog2(DEPTH);

    rd_state_e         st_q, st_d;
    logic [BW-1:0]     rbits_q;
    logic [RW-1:0]     rcnt_q;
    logic [RW-1:0]     rgray_q;
    logic [PW-1:0]     wg_s;
    logic [OUT_W-1:0]  word;

    int unsigned ofs, wbits, rb, avail, rmod, rnxt;

    gbx_sync #(.W(PW), .RST_VAL(PW'(to_gray(WBASE)))) u_wg_sync (
        .clk(clk), .rst_n(rst_n), .d(wr_gray), .q(wg_s)
    );

    always_comb begin
        ofs   = (32'(align_ofs) > OUT_W - 1) ? (OUT_W - 1) : 32'(align_ofs);
        wbits = (from_gray(32'(wg_s)) - WBASE) * IN_W;
        rb    = 32'(rbits_q);
        avail = (wbits >= rb) ? (wbits - rb) : (wbits + SPAN - rb);
        rmod  = rb % DEPTH;
        rnxt  = (32'(rcnt_q) == RBASE + RST - 1) ? RBASE : 32'(rcnt_q) + 1;
    end

    // One tap per output bit, each rotating through the store.
    for (genvar i = 0; i < OUT_W; i++) begin : g_tap
        logic [AW-1:0] idx;
        always_comb begin
            idx     = AW'((rmod + i) % DEPTH);
            word[i] = mem[idx];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_ALIGN:  if (avail >= ofs) st_d = RS_STREAM;
            RS_STREAM: st_d = RS_STREAM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_ALIGN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbits_q   <= '0;
            rcnt_q    <= RW'(RBASE);
            rgray_q   <= RW'(to_gray(RBASE));
            dout      <= '0;
            out_valid <= 1'b0;
        end else begin
            unique case (st_q)
                RS_ALIGN: begin
                    out_valid <= 1'b0;
                    if (avail >= ofs) rbits_q <= BW'((rb + ofs) % SPAN);
                end
                RS_STREAM: begin
                    if (avail >= OUT_W) begin
                        dout      <= word;
                        out_valid <= 1'b1;
                        rbits_q   <= BW'((rb + OUT_W) % SPAN);
                        rcnt_q    <= RW'(rnxt);
                        rgray_q   <= RW'(to_gray(rnxt));
                    end else begin
                        out_valid <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign rd_gray = rgray_q;
    assign rd_flag = {(st_q == RS_STREAM), OFS_W'(ofs)};

    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray_q ^ $past(rgray_q)) <= 1); // R4
    AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= DEPTH); // R7
    AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_ALIGN) |-> !out_valid); // R5

endmodule

// File: rtl/lane_gearbox.sv
`timescale 1ns/1ps
module lane_gearbox #(
    parameter int unsigned IN_W  = 2,
    parameter int unsigned OUT_W = 7,
    parameter int unsigned DEPTH = 56
) (
    input  logic                     wclk,
    input  logic                     wrst_n,
    input  logic                     din_valid,
    input  logic [IN_W-1:0]          din,
    output logic                     overflow,
    input  logic                     rclk,
    input  logic                     rrst_n,
    input  logic [$clog2(OUT_W)-1:0] align_ofs,
    output logic [OUT_W-1:0]         dout,
    output logic                     out_valid
);

    localparam int unsigned PW    = $clog2(2 * DEPTH / IN_W);
    localparam int unsigned RW    = $clog2(2 * DEPTH / OUT_W);
    localparam int unsigned OFS_W = $clog2(OUT_W);

    logic [PW-1:0]    wr_gray;
    logic [RW-1:0]    rd_gray;
    logic [OFS_W:0]   rd_flag;
    logic [DEPTH-1:0] mem;

    gbx_wr #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .din_valid(din_valid), .din(din),
        .rd_gray(rd_gray), .rd_flag(rd_flag),
        .wr_gray(wr_gray), .mem(mem), .overflow(overflow)
    );

    gbx_rd #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .align_ofs(align_ofs),
        .wr_gray(wr_gray), .mem(mem),
        .rd_gray(rd_gray), .rd_flag(rd_flag),
        .dout(dout), .out_valid(out_valid)
    );

endmodule

// File: tb/sim_lane_gearbox.sv
`timescale 1ns/1ps
module sim_lane_gearbox;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       wrst_n = 1'b0;
    logic       rrst_n = 1'b0;
    logic       din_valid = 1'b0;
    logic [1:0] din = 2'b00;
    logic [2:0] align_ofs = 3'd0;
    logic       overflow;
    logic [6:0] dout;
    logic       out_valid;

    int    n_chk = 0;
    int    n_fail = 0;
    int    nwords = 0;
    int    skip_left = 0;
    bit    expq[$];
    string cur_req = "R2";
    bit    done = 1'b0;

    always #5 rclk = ~rclk;
    always #7 wclk = ~wclk;

    lane_gearbox u0 (
        .wclk(wclk), .wrst_n(wrst_n), .din_valid(din_valid), .din(din),
        .overflow(overflow), .rclk(rclk), .rrst_n(rrst_n),
        .align_ofs(align_ofs), .dout(dout), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: every valid read cycle takes the next 7 queued bits.
    always @(negedge rclk) begin
        if (rrst_n && out_valid) begin
            logic [6:0] ew;
            while (skip_left > 0 && expq.size() > 0) begin
                void'(expq.pop_front());
                skip_left--;
            end
            if (expq.size() < 7) begin
                chk(1'b0, "R3 valid with too few bits", expq.size(), 7);
            end else begin
                for (int k = 0; k < 7; k++) ew[k] = expq.pop_front();
                chk(dout == ew, cur_req, int'(dout), int'(ew));
            end
            nwords++;
        end
    end

    task automatic do_reset(input logic [2:0] ofs, input bit hold_rd);
        @(negedge wclk);
        wrst_n = 1'b0; rrst_n = 1'b0; din_valid = 1'b0; align_ofs = ofs;
        repeat (4) @(negedge rclk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(overflow == 1'b0, "R1 overflow in reset", int'(overflow), 0);
        expq.delete();
        nwords = 0;
        skip_left = (ofs > 3'd6) ? 6 : int'(ofs);
        @(negedge wclk) wrst_n = 1'b1;
        if (!hold_rd) begin
            @(negedge rclk) rrst_n = 1'b1;
        end
    endtask

    task automatic wr(input logic [1:0] p, input bit acc);
        @(negedge wclk);
        din_valid = 1'b1;
        din = p;
        if (acc) begin
            expq.push_back(p[0]);
            expq.push_back(p[1]);
        end
    endtask

    task automatic idle_w(input int n);
        repeat (n) begin
            @(negedge wclk);
            din_valid = 1'b0;
        end
    endtask

    task automatic settle();
        idle_w(4);
        repeat (40) @(negedge rclk);
    endtask

    initial begin
        // Phase A: bursty random stream over many laps
        do_reset(3'd0, 1'b0);
        repeat (20) @(negedge rclk);
        chk(nwords == 0, "R1 no word from empty store", nwords, 0);
        cur_req = "R2 random word";
        for (int i = 0; i < 700; i++) begin
            if ($urandom_range(4) == 0) idle_w(1);
            wr(2'($urandom), 1'b1);
        end
        settle();
        chk(nwords == 200, "R4 words after many laps", nwords, 200);
        chk(expq.size() == 0, "R2 pending bits", expq.size(), 0);
        chk(overflow == 1'b0, "R9 no overflow when streaming", int'(overflow), 0);
        for (int i = 0; i < 3; i++) wr(2'b11, 1'b1);
        settle();
        chk(nwords == 200, "R3 six bits give no word", nwords, 200);
        wr(2'b01, 1'b1);
        settle();
        chk(nwords == 201, "R3 seventh bit completes word", nwords, 201);
        chk(expq.size() == 1, "R3 remainder", expq.size(), 1);

        // Phase B: offset 3, pairs whose bits differ
        do_reset(3'd3, 1'b0);
        cur_req = "R5 offset 3 word";
        for (int i = 0; i < 400; i++) wr(2'b10, 1'b1);
        settle();
        chk(nwords == 113, "R5 word count offset 3", nwords, 113);
        chk(expq.size() == 6, "R5 remainder offset 3", expq.size(), 6);
        chk(overflow == 1'b0, "R9 no overflow offset 3", int'(overflow), 0);

        // Phase C: offset 7 clamps to 6
        do_reset(3'd7, 1'b0);
        cur_req = "R6 clamped offset word";
        for (int i = 0; i < 350; i++) wr(2'($urandom), 1'b1);
        settle();
        chk(nwords == 99, "R6 word count offset 7", nwords, 99);
        chk(expq.size() == 1, "R6 remainder offset 7", expq.size(), 1);

        // Phase D: reader held in reset, writer fills the store
        do_reset(3'd0, 1'b1);
        cur_req = "R8 word after overflow";
        for (int i = 0; i < 28; i++) wr(2'(i), 1'b1);
        idle_w(2);
        chk(overflow == 1'b0, "R7 exactly full no flag", int'(overflow), 0);
        wr(2'b11, 1'b0);
        idle_w(1);
        chk(overflow == 1'b1, "R7 flag after refused write", int'(overflow), 1);
        wr(2'b10, 1'b0);
        idle_w(2);
        @(negedge rclk) rrst_n = 1'b1;
        repeat (60) @(negedge rclk);
        chk(nwords == 8, "R8 only accepted bits read", nwords, 8);
        chk(overflow == 1'b1, "R7 flag sticky", int'(overflow), 1);
        wr(2'b00, 1'b1); wr(2'b01, 1'b1); wr(2'b11, 1'b1); wr(2'b10, 1'b1);
        settle();
        chk(nwords == 9, "R8 new data after space freed", nwords, 9);
        chk(overflow == 1'b1, "R7 flag held until write reset", int'(overflow), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule